// File: doc/BRIEF.md
# Programmable Packed-Pixel Field Extractor

The block takes 32-bit words that hold packed RGB pixel units and produces one pixel per output transfer as four 8-bit components: alpha, red, green and blue. Configuration inputs choose the unit width, 16 or 32 bits. They also choose little- or big-endian byte order. For each of the four components they give a start bit and a field length.

An accepted word is kept in a single holding register. In big-endian mode the byte order of the held word is reversed. The active unit is then picked from the word. With 32-bit units the word is the unit. With 16-bit units the word holds two units, which are delivered one after the other. Each field is shifted out of the unit, masked to its length and widened to 8 bits by repeating its own bits. Input and output use valid/ready handshakes. A new word can enter in the same cycle as the last pixel of the current word leaves, so a continuous stream has no gap.

Top module: `pix_unpack`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `unit32`=1 and `big_end`=0, the unit is `in_data` unchanged. Component value bit j comes from unit bit (start + j).
- R3: With `big_end`=1, the word is byte-reversed before the unit is selected. Bits 7:0 move to 31:24, bits 15:8 to 23:16, bits 23:16 to 15:8, and bits 31:24 to 7:0.
- R4: With `unit32`=0, each word gives two pixels. In little-endian mode the first pixel comes from bits 15:0 and the second from bits 31:16. In big-endian mode the word is byte-reversed (R3) and the upper half comes first.
- R5: A field of length L (1..8) is widened to 8 bits by repeating its bit pattern, most significant bit first, from bit 7 downward. For example, 3'b101 becomes 8'hB6 and an all-ones field becomes 8'hFF. Lengths 9 to 15 act as length 8.
- R6: Field bits at or above the unit width read as 0. That means bit 16 and up for 16-bit units, and bit 32 and up for 32-bit units.
- R7: An alpha length of 0 gives alpha = 8'hFF. A red, green or blue length of 0 gives that component 8'h00.
- R8: `out_valid` stays high until every pixel of the held word has been taken. While `out_ready` is low, the pixel shown does not change, provided the configuration does not change.
- R9: `in_ready` is 1 only when no pixel is pending, or when the last pending pixel of the held word is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit32 | input | 1 | 1: 32-bit units, 0: 16-bit units |
| big_end | input | 1 | 1: byte-reversed (big-endian) words |
| a_pos | input | 5 | Alpha start bit |
| r_pos | input | 5 | Red start bit |
| g_pos | input | 5 | Green start bit |
| b_pos | input | 5 | Blue start bit |
| a_len | input | 4 | Alpha length, 0 = absent |
| r_len | input | 4 | Red length |
| g_len | input | 4 | Green length |
| b_len | input | 4 | Blue length |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| in_data | input | 32 | Packed input word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_a | output | 8 | Alpha |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
Two things can happen in one cycle: the last pixel of a held word is handed out, and the next word is accepted. The bench provokes this by keeping `in_valid` asserted while `out_ready` toggles at random, in both unit widths. In every cycle it compares `in_ready` and `out_valid` against a count of the pixels it expects to be pending. Every pixel that leaves is compared against a reference queue, so a lost, repeated or reordered pixel at that overlap shows up as a mismatch.

// File: rtl/pix_unpack.sv
module pix_unpack #(
  parameter int WORD_W = 32,
  parameter int COMP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      unit32,
  input  logic                      big_end,
  input  logic [$clog2(WORD_W)-1:0] a_pos,
  input  logic [$clog2(WORD_W)-1:0] r_pos,
  input  logic [$clog2(WORD_W)-1:0] g_pos,
  input  logic [$clog2(WORD_W)-1:0] b_pos,
  input  logic [$clog2(COMP_W):0]   a_len,
  input  logic [$clog2(COMP_W):0]   r_len,
  input  logic [$clog2(COMP_W):0]   g_len,
  input  logic [$clog2(COMP_W):0]   b_len,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [WORD_W-1:0]         in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [COMP_W-1:0]         out_a,
  output logic [COMP_W-1:0]         out_r,
  output logic [COMP_W-1:0]         out_g,
  output logic [COMP_W-1:0]         out_b
);
  localparam int POS_W = $clog2(WORD_W);
  localparam int LEN_W = $clog2(COMP_W) + 1;
  localparam int HALF  = WORD_W / 2;
  localparam int NB    = WORD_W / 8;

  logic [WORD_W-1:0] word_q, swapped, ordered, unit;
  logic              slot_q, full_q, last;

  always_comb
    for (int b = 0; b < NB; b++)
      swapped[8*b +: 8] = word_q[8*(NB-1-b) +: 8];

  assign ordered = big_end ? swapped : word_q;

  always_comb begin
    if (unit32)
      unit = ordered;
    else if (slot_q ^ big_end)
      unit = {{HALF{1'b0}}, ordered[WORD_W-1:HALF]};
    else
      unit = {{HALF{1'b0}}, ordered[HALF-1:0]};
  end

  function automatic logic [COMP_W-1:0] grab(input logic [WORD_W-1:0] u,
                                              input logic [POS_W-1:0]  p,
                                              input logic [LEN_W-1:0]  l,
                                              input logic [COMP_W-1:0] none);
    logic [WORD_W-1:0] sh;
    logic [COMP_W-1:0] v, x, r;
    int w;
    w = (int'(l) > COMP_W) ? COMP_W : int'(l);
    if (w == 0) return none;
    sh = u >> p;
    v  = sh[COMP_W-1:0] & COMP_W'((32'd1 << w) - 32'd1);
    x  = v << (COMP_W - w);
    r  = x;
    for (int k = 1; k < COMP_W; k++) r = r | (x >> (k * w));
    return r;
  endfunction

  assign out_a = grab(unit, a_pos, a_len, '1);
  assign out_r = grab(unit, r_pos, r_len, '0);
  assign out_g = grab(unit, g_pos, g_len, '0);
  assign out_b = grab(unit, b_pos, b_len, '0);

  assign last      = unit32 | slot_q;
  assign out_valid = full_q;
  assign in_ready  = !full_q || (out_ready && last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      slot_q <= 1'b0;
      full_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      word_q <= in_data;
      slot_q <= 1'b0;
      full_q <= 1'b1;
    end else if (out_valid && out_ready) begin
      if (last) full_q <= 1'b0;
      else      slot_q <= 1'b1;
    end
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(word_q) && $stable(slot_q));

  p_no_accept_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_load_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && !slot_q);

  p_second_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !unit32 && !slot_q && !in_valid |=> out_valid && slot_q);

  p_absent_alpha_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && a_len == '0 |-> out_a == '1);
endmodule

// File: tb/pix_unpack_test.sv
module pix_unpack_test;
  logic clk = 0, rst_n = 0;
  logic unit32 = 1, big_end = 0;
  logic [4:0] a_pos = 0, r_pos = 0, g_pos = 0, b_pos = 0;
  logic [3:0] a_len = 0, r_len = 0, g_len = 0, b_len = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [31:0] in_data = 0;
  logic [7:0] out_a, out_r, out_g, out_b;
  int checks = 0, fails = 0;
  logic [31:0] q[$];

  always #5 clk = ~clk;

  pix_unpack uut (.clk(clk), .rst_n(rst_n), .unit32(unit32), .big_end(big_end),
    .a_pos(a_pos), .r_pos(r_pos), .g_pos(g_pos), .b_pos(b_pos),
    .a_len(a_len), .r_len(r_len), .g_len(g_len), .b_len(b_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_a(out_a), .out_r(out_r), .out_g(out_g), .out_b(out_b));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] widen(logic [7:0] v, int w);
    logic [63:0] acc = 0;
    int filled = 0;
    while (filled < 8) begin acc = (acc << w) | 64'(v); filled += w; end
    return 8'(acc >> (filled - 8));
  endfunction

  function automatic logic [7:0] fld(logic [31:0] u, int uw, int p, int l, bit isa);
    logic [7:0] v = 0;
    int w = (l > 8) ? 8 : l;
    if (w == 0) return isa ? 8'hFF : 8'h00;
    for (int j = 0; j < w; j++) if (p + j < uw) v[j] = u[p+j];
    return widen(v, w);
  endfunction

  function automatic logic [31:0] model(logic [31:0] wd, int k);
    logic [7:0] m[4];
    logic [31:0] u;
    int uw;
    for (int i = 0; i < 4; i++) m[i] = wd[8*i +: 8];
    if (unit32) begin
      u = big_end ? {m[0], m[1], m[2], m[3]} : wd; uw = 32;
    end else begin
      u = big_end ? {16'h0, m[2*k], m[2*k+1]} : {16'h0, m[2*k+1], m[2*k]}; uw = 16;
    end
    return {fld(u, uw, a_pos, a_len, 1), fld(u, uw, r_pos, r_len, 0),
            fld(u, uw, g_pos, g_len, 0), fld(u, uw, b_pos, b_len, 0)};
  endfunction

  task automatic setcfg(bit u, bit be, int pa, int la, int pr, int lr,
                        int pg, int lg, int pb, int lb);
    unit32 = u; big_end = be;
    a_pos = 5'(pa); a_len = 4'(la); r_pos = 5'(pr); r_len = 4'(lr);
    g_pos = 5'(pg); g_len = 4'(lg); b_pos = 5'(pb); b_len = 4'(lb);
  endtask

  task automatic direct(string tag, logic [31:0] wd, logic [31:0] e0, logic [31:0] e1);
    @(negedge clk); in_valid = 1; in_data = wd; out_ready = 0;
    @(negedge clk); in_valid = 0; #1;
    check({tag, " pixel0"}, {out_a, out_r, out_g, out_b}, e0);
    out_ready = 1;
    if (!unit32) begin
      @(negedge clk); #1;
      check({tag, " pixel1"}, {out_a, out_r, out_g, out_b}, e1);
    end
    @(negedge clk); out_ready = 0; #1;
    check({tag, " drained R8"}, 32'(out_valid), 0);
  endtask

  task automatic stream(int nwords);
    int sent = 0, guard = 0;
    bit pend = 0;
    logic [31:0] e;
    while ((sent < nwords || q.size() != 0 || pend) && guard < 4000) begin
      guard++;
      @(negedge clk);
      if (!pend) begin
        in_valid = (sent < nwords) && ($urandom_range(0, 9) < 7);
        if (in_valid) begin in_data = $urandom; pend = 1; end
      end
      out_ready = $urandom_range(0, 9) < 6;
      #1;
      check("R8 out_valid vs pending", 32'(out_valid), 32'(q.size() != 0));
      check("R9 in_ready vs pending", 32'(in_ready),
            32'((q.size() == 0) || (out_ready && q.size() == 1)));
      if (out_valid && out_ready && q.size() != 0) begin
        e = q.pop_front();
        check(unit32 ? "R2/R3/R5/R6/R7 pixel32" : "R4/R5/R6/R7 pixel16",
              {out_a, out_r, out_g, out_b}, e);
      end
      if (in_valid && in_ready) begin
        q.push_back(model(in_data, 0));
        if (!unit32) q.push_back(model(in_data, 1));
        pend = 0; sent++;
      end
    end
    @(negedge clk); in_valid = 0; out_ready = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    #1; check("R1 reset out_valid", 32'(out_valid), 0);
    check("R1 reset in_ready", 32'(in_ready), 1);
    repeat (2) @(negedge clk);
    rst_n = 1;

    setcfg(1, 0, 24, 8, 16, 8, 8, 8, 0, 8);
    direct("R2 little 32", 32'h80FF4C21, 32'h80FF4C21, 0);
    setcfg(1, 1, 24, 8, 16, 8, 8, 8, 0, 8);
    direct("R3 big 32", 32'h80FF4C21, 32'h214CFF80, 0);
    setcfg(0, 0, 0, 0, 11, 5, 5, 6, 0, 5);
    direct("R4 little 16", 32'hF80007E0, 32'hFF00FF00, 32'hFFFF0000);
    setcfg(0, 1, 0, 0, 8, 8, 0, 8, 12, 8);
    direct("R4 R6 big 16", 32'h78563412, 32'hFF123401, 32'hFF567805);
    setcfg(1, 0, 30, 4, 8, 5, 5, 1, 0, 3);
    direct("R5 R6 widen", 32'h00001025, 32'h0084FFB6, 0);
    setcfg(1, 0, 0, 0, 0, 0, 0, 12, 4, 0);
    direct("R5 R7 zero len", 32'h000000AB, 32'hFF00AB00, 0);

    for (int ph = 0; ph < 24; ph++) begin
      setcfg($urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 31), $urandom_range(0, 10),
             $urandom_range(0, 31), $urandom_range(0, 10),
             $urandom_range(0, 31), $urandom_range(0, 10),
             $urandom_range(0, 31), $urandom_range(0, 10));
      stream(40);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule